// File: doc/BRIEF.md
# Accumulator Add/Subtract Unit with Status Flags

This block is the arithmetic and status core of a small 8-bit controller. It holds the accumulator and a status byte. On each strobed cycle it carries out one operation: add, add with carry, subtract with borrow, clear, set or invert the carry flag, write the status byte directly, or apply the flag effect of a multiply or divide that runs elsewhere. Instruction decode sits upstream and presents a 3-bit operation code, an 8-bit operand and a strobe.

The status byte is laid out, from bit 7 down to bit 0, as carry (CY), nibble carry (AC), user flag, bank select high, bank select low, signed overflow (OV), user bit, and parity (P). Parity is never stored. It is recomputed from the accumulator every cycle. The two bank-select bits drive a separate output that gives the first address of the selected group of eight working registers.

Top module: `acc_flag_alu`

## Requirements
- R1: After a clock edge with rst_n low, acc_o is 00H, psw_o is 00H and bank_base_o is 0.
- R2: With stb_i high and op_i = 0 (ADD), the accumulator becomes (acc + operand) mod 256. CY (bit 7) becomes the carry out of bit 7, and AC (bit 6) becomes the carry from bit 3 into bit 4. For example, 38H + 2FH gives 67H with CY=0, AC=1 and P=1, and 9CH + 64H gives 00H with CY=1, AC=1 and P=0.
- R3: With op_i = 1 (ADDC), the current CY is added as a carry-in, and CY and AC are set as in R2.
- R4: With op_i = 2 (SUBB), the accumulator becomes acc − operand − CY. CY is set to the borrow out of bit 7, and AC to the borrow out of bit 3.
- R5: For op_i 0, 1 and 2, OV (bit 2) is set exactly when the result overflows as a signed two's-complement value.
- R6: P (bit 0) is 1 whenever the accumulator holds an odd number of ones and 0 otherwise, on every cycle.
- R7: op_i = 3 clears CY, op_i = 4 sets CY and op_i = 5 inverts CY. None of these three changes the accumulator or any other status bit.
- R8: op_i = 6 loads status bits 7 to 1 from operand bits 7 to 1. Operand bit 0 is ignored, and P still follows the accumulator.
- R9: op_i = 7 (multiply/divide flag effect) clears CY and loads OV from ovf_i. The accumulator and all other bits are left unchanged.
- R10: bank_base_o equals 8 × {psw bit 4, psw bit 3}, which gives 00H, 08H, 10H or 18H.
- R11: While stb_i is low, the accumulator and status bits 7 to 1 hold their values.
- R12: Arithmetic operations (op_i 0 to 2) leave bits 5, 4, 3 and 1 of the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| stb_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (0 to 7) |
| operand_i | input | 8 | Operand B, or the status value for a direct write |
| ovf_i | input | 1 | OV value supplied by an external multiply or divide |
| acc_o | output | 8 | Accumulator |
| psw_o | output | 8 | Status byte |
| bank_base_o | output | 5 | First address of the selected register bank |

## Verification
On every cycle the assertions check the carry-bit operations, the direct status write, the multiply/divide flag effect, and holding while the strobe is idle. They also check that arithmetic preserves the bank and user bits, that parity follows the accumulator's bit count, and that the bank base stays aligned to the select bits. The numeric results of the adds and subtracts cannot be shown that way: the sums, the nibble carries and borrows, and signed overflow on both sides of zero. Those are shown only by the bench's sequence of hand-computed vectors, including the two worked additions and a borrow that wraps through FFH.

// File: rtl/alu_pkg.sv
// Package alu_pkg: operation codes and status-byte bit positions shared
// by the accumulator unit and its submodules.
// Assumes an 8-bit status byte whose bit order is fixed by the controller.
package alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD    = 3'd0,
        OP_ADDC   = 3'd1,
        OP_SUBB   = 3'd2,
        OP_CLRC   = 3'd3,
        OP_SETBC  = 3'd4,
        OP_CPLC   = 3'd5,
        OP_PSWWR  = 3'd6,
        OP_MULDIV = 3'd7
    } alu_op_e;

    localparam int STAT_W = 8;
    localparam int B_CY   = 7;
    localparam int B_AC   = 6;
    localparam int B_UF   = 5;
    localparam int B_BS1  = 4;
    localparam int B_BS0  = 3;
    localparam int B_OV   = 2;
    localparam int B_UB   = 1;
    localparam int B_P    = 0;
endpackage

// File: rtl/alu_addsub.sv
// Module alu_addsub: ripple add/subtract that exposes the carry out of the
// top bit, the nibble carry and signed overflow.
// Assumes DATA_W is even and at least 4. For subtraction, carries are
// reported as borrows.
module alu_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o,
    output logic              ac_o,
    output logic              ov_o
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] eff_b;
    logic [DATA_W:0]   carry;

    // Invert the operand and the incoming borrow so subtraction reuses the adder.
    assign eff_b    = sub_i ? ~b_i : b_i;
    assign carry[0] = sub_i ? ~cin_i : cin_i;

    // One full-adder stage per bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign res_o[i]   = a_i[i] ^ eff_b[i] ^ carry[i];
        assign carry[i+1] = (a_i[i] & eff_b[i]) | (a_i[i] & carry[i]) | (eff_b[i] & carry[i]);
    end

    // Turn the raw carries into flag values. A borrow is an inverted carry.
    assign cy_o = carry[DATA_W] ^ sub_i;
    assign ac_o = carry[HALF] ^ sub_i;
    assign ov_o = carry[DATA_W-1] ^ carry[DATA_W];
endmodule

// File: rtl/alu_parity.sv
// Module alu_parity: odd-parity indicator of a data word.
// Assumes a purely combinational use. The output is 1 for an odd count of ones.
module alu_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    output logic              odd_o
);
    // XOR-reduce the word.
    assign odd_o = ^data_i;
endmodule

// File: rtl/alu_bank.sv
// Module alu_bank: converts the two bank-select bits into the first address
// of the selected group of BANK_REGS working registers.
// Assumes BANK_REGS is a power of two.
module alu_bank #(
    parameter int BANK_REGS = 8
) (
    input  logic [1:0]                      sel_i,
    output logic [$clog2(BANK_REGS)+1:0]    base_o
);
    localparam int SHIFT = $clog2(BANK_REGS);

    // Base equals the bank number scaled by the bank size.
    assign base_o = {sel_i, {SHIFT{1'b0}}};
endmodule

// File: rtl/acc_flag_alu.sv
// Module acc_flag_alu: accumulator plus status byte, updated by one strobed
// operation per cycle. Parity is derived from the accumulator, not stored.
// Assumes operations arrive already decoded. Multiply and divide run
// elsewhere and report only their overflow through ovf_i.
module acc_flag_alu #(
    parameter int DATA_W    = 8,
    parameter int BANK_REGS = 8,
    localparam int BASE_W   = $clog2(BANK_REGS) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              ovf_i,
    output logic [DATA_W-1:0] acc_o,
    output logic [7:0]        psw_o,
    output logic [BASE_W-1:0] bank_base_o
);
    import alu_pkg::*;

    alu_op_e           op_e;
    logic [DATA_W-1:0] acc_q, acc_d;
    logic [7:1]        stat_q, stat_d;
    logic [DATA_W-1:0] sum;
    logic              sum_cy, sum_ac, sum_ov, is_sub, cin, par;

    // Present the raw code as the enumerated operation.
    assign op_e   = alu_op_e'(op_i);
    assign is_sub = (op_e == OP_SUBB);
    assign cin    = (op_e == OP_ADD) ? 1'b0 : stat_q[B_CY];

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i(acc_q), .b_i(operand_i), .cin_i(cin), .sub_i(is_sub),
        .res_o(sum), .cy_o(sum_cy), .ac_o(sum_ac), .ov_o(sum_ov)
    );

    alu_parity #(.DATA_W(DATA_W)) u_parity (.data_i(acc_q), .odd_o(par));

    alu_bank #(.BANK_REGS(BANK_REGS)) u_bank (
        .sel_i({stat_q[B_BS1], stat_q[B_BS0]}), .base_o(bank_base_o)
    );

    // Select the next accumulator and stored status bits from the operation.
    always_comb begin
        acc_d  = acc_q;
        stat_d = stat_q;
        if (stb_i) begin
            unique case (op_e)
                OP_ADD, OP_ADDC, OP_SUBB: begin
                    acc_d        = sum;
                    stat_d[B_CY] = sum_cy;
                    stat_d[B_AC] = sum_ac;
                    stat_d[B_OV] = sum_ov;
                end
                OP_CLRC:   stat_d[B_CY] = 1'b0;
                OP_SETBC:  stat_d[B_CY] = 1'b1;
                OP_CPLC:   stat_d[B_CY] = ~stat_q[B_CY];
                OP_PSWWR:  stat_d = operand_i[7:1];
                OP_MULDIV: begin
                    stat_d[B_CY] = 1'b0;
                    stat_d[B_OV] = ovf_i;
                end
                default: ;
            endcase
        end
    end

    // Register the accumulator and status bits with a synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            stat_q <= '0;
        end else begin
            acc_q  <= acc_d;
            stat_q <= stat_d;
        end
    end

    assign acc_o = acc_q;
    assign psw_o = {stat_q, par};

    // R7
    clrc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && op_e == OP_CLRC) |=> (psw_o[B_CY] == 1'b0 && $stable(acc_o) && $stable(psw_o[6:1])));
    // R7
    setbc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && op_e == OP_SETBC) |=> (psw_o[B_CY] == 1'b1 && $stable(acc_o) && $stable(psw_o[6:1])));
    // R7
    cplc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && op_e == OP_CPLC) |=> (psw_o[B_CY] != $past(psw_o[B_CY]) && $stable(acc_o)));
    // R8
    pswwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && op_e == OP_PSWWR) |=> (psw_o[7:1] == $past(operand_i[7:1]) && $stable(acc_o)));
    // R9
    muldiv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && op_e == OP_MULDIV) |=> (!psw_o[B_CY] && psw_o[B_OV] == $past(ovf_i) && $stable(acc_o)));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> ($stable(acc_o) && $stable(psw_o[7:1])));
    // R12
    arith_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && (op_e == OP_ADD || op_e == OP_ADDC || op_e == OP_SUBB))
        |=> ($stable(psw_o[5:3]) && $stable(psw_o[B_UB])));
    // R6
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psw_o[B_P] == ($countones(acc_o) % 2 == 1));
    // R10
    bank_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_base_o[BASE_W-3:0] == '0) && (bank_base_o[BASE_W-1:BASE_W-2] == psw_o[4:3]));
endmodule

// File: tb/acc_flag_alu_tb.sv
// Bench acc_flag_alu_tb: walks a table of operations with hand-computed
// results, then runs directed reset, idle and parity cases.
module acc_flag_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb_i = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic [7:0] operand_i = 8'h00;
    logic       ovf_i = 1'b0;
    logic [7:0] acc_o, psw_o;
    logic [4:0] bank_base_o;
    int         errors = 0;
    int         checks = 0;

    always #2.5 clk = ~clk;

    acc_flag_alu u_dut (
        .clk(clk), .rst_n(rst_n), .stb_i(stb_i), .op_i(op_i),
        .operand_i(operand_i), .ovf_i(ovf_i), .acc_o(acc_o),
        .psw_o(psw_o), .bank_base_o(bank_base_o)
    );

    // Entry layout: {op, operand, ovf, exp_acc, exp_psw, exp_bank}.
    localparam int NV = 19;
    localparam logic [32:0] VEC [NV] = '{
        {3'd0, 8'h38, 1'b0, 8'h38, 8'h01, 5'h00}, // R2 R6
        {3'd0, 8'h2F, 1'b0, 8'h67, 8'h41, 5'h00}, // R2 example 1
        {3'd0, 8'h35, 1'b0, 8'h9C, 8'h04, 5'h00}, // R5 positive overflow
        {3'd0, 8'h64, 1'b0, 8'h00, 8'hC0, 5'h00}, // R2 example 2
        {3'd1, 8'h10, 1'b0, 8'h11, 8'h00, 5'h00}, // R3 carry-in used
        {3'd4, 8'h00, 1'b0, 8'h11, 8'h80, 5'h00}, // R7 set
        {3'd2, 8'h05, 1'b0, 8'h0B, 8'h41, 5'h00}, // R4 nibble borrow
        {3'd2, 8'h0C, 1'b0, 8'hFF, 8'hC0, 5'h00}, // R4 wrap borrow
        {3'd2, 8'h7F, 1'b0, 8'h7F, 8'h45, 5'h00}, // R5 subtract overflow
        {3'd5, 8'h00, 1'b0, 8'h7F, 8'hC5, 5'h00}, // R7 invert
        {3'd5, 8'h00, 1'b0, 8'h7F, 8'h45, 5'h00}, // R7 invert back
        {3'd6, 8'hFF, 1'b0, 8'h7F, 8'hFF, 5'h18}, // R8 R10 bank 3
        {3'd3, 8'h00, 1'b0, 8'h7F, 8'h7F, 5'h18}, // R7 clear
        {3'd6, 8'h08, 1'b0, 8'h7F, 8'h09, 5'h08}, // R8 bit0 ignored, R10
        {3'd6, 8'h10, 1'b0, 8'h7F, 8'h11, 5'h10}, // R10 bank 2
        {3'd4, 8'h00, 1'b0, 8'h7F, 8'h91, 5'h10}, // R7
        {3'd7, 8'h00, 1'b1, 8'h7F, 8'h15, 5'h10}, // R9 OV loaded
        {3'd7, 8'h00, 1'b0, 8'h7F, 8'h11, 5'h10}, // R9 OV cleared
        {3'd0, 8'h01, 1'b0, 8'h80, 8'h55, 5'h10}  // R12 bank kept, R5
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] op, input logic [7:0] opnd, input logic ovf, input logic stb);
        @(negedge clk);
        op_i = op; operand_i = opnd; ovf_i = ovf; stb_i = stb;
        @(negedge clk);
        stb_i = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 acc", acc_o, 8'h00);
        check("R1 psw", psw_o, 8'h00);
        check("R1 bank", {3'b0, bank_base_o}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][32:30], VEC[i][29:22], VEC[i][21], 1'b1);
            check($sformatf("R2-table acc v%0d", i), acc_o, VEC[i][20:13]);
            check($sformatf("R5-table psw v%0d", i), psw_o, VEC[i][12:5]);
            check($sformatf("R10 bank v%0d", i), {3'b0, bank_base_o}, {3'b0, VEC[i][4:0]});
        end

        // R11: strobe low with an ADD presented leaves everything unchanged.
        step(3'd0, 8'h22, 1'b1, 1'b0);
        check("R11 acc", acc_o, 8'h80);
        check("R11 psw", psw_o, 8'h55);
        step(3'd6, 8'h00, 1'b0, 1'b0);
        check("R11 psw write idle", psw_o, 8'h55);

        // R1: reset mid-run returns to zero.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 acc rerun", acc_o, 8'h00);
        check("R1 psw rerun", psw_o, 8'h00);
        rst_n = 1'b1;

        // R8 R6: direct write of bit 0 cannot set P while acc is 00H.
        step(3'd6, 8'h01, 1'b0, 1'b1);
        check("R8 P not written", psw_o, 8'h00);

        // R3: ADDC with CY set: FFH + 00H + 1 = 00H, CY=1, AC=1.
        step(3'd6, 8'h80, 1'b0, 1'b1);
        step(3'd0, 8'hFF, 1'b0, 1'b1);
        check("R2 FF acc", acc_o, 8'hFF);
        step(3'd4, 8'h00, 1'b0, 1'b1);
        step(3'd1, 8'h00, 1'b0, 1'b1);
        check("R3 acc", acc_o, 8'h00);
        check("R3 psw", psw_o, 8'hC0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule